// File: doc/BRIEF.md
# Host Command Register with Channel Dispatch

This block is a 16-bit command register through which a host processor hands work to a communication engine. The host writes one word that carries an opcode, a target channel number, a "go" flag and a soft-reset request. When the word asks for a command, the block latches the opcode and channel and emits a single-cycle strobe on the addressed channel's valid line. It then holds the go flag, now acting as a busy indicator, at 1 until that channel reports completion.

Writing the soft-reset request starts a module-wide reinitialization. The request bit and the busy bit both clear on their own within two clocks. A reset-active output then stays high for a fixed, parameterised number of cycles, 60 by default. While it is high, the command path is locked. The sequence runs in the background, so the host may carry on setting up other registers while it runs. Both the reset request and the busy bit are cleared by the block and never by the host.

Top module: `cpcmd_reg`

## Requirements
- R1: Readback layout uses bit 15 for the reset request, bits 11:8 for the opcode, bits 7:4 for the channel and bit 0 for busy. Bits 14:12 and 3:1 always read 0, whatever is written to them.
- R2: After reset, rd_data reads 0, cmd_valid is 0 and rst_active is 0.
- R3: The host cannot clear the reset-request or busy bits. When idle, a write with bit 15 and bit 0 both 0 only updates the opcode and channel fields, and raises no strobe.
- R4: An accepted command write (idle, bit 15 = 0, bit 0 = 1) sets busy. In the cycle after the write edge, it drives cmd_valid one-hot on the written channel for exactly one cycle, with cmd_op equal to the written opcode.
- R5: Busy clears at the edge where chan_done of the latched channel is high. A done pulse on any other channel has no effect.
- R6: A write with bit 15 = 0 that arrives while busy is ignored. The fields do not change and no strobe is raised.
- R7: A reset write (bit 15 = 1) reads back 1 for one cycle. At the next edge both bit 15 and bit 0 read 0.
- R8: rst_active rises in the cycle that bit 15 clears and stays high for exactly RST_CYCLES cycles (60 by default).
- R9: While the reset request is pending or rst_active is high, every write is ignored and no command strobe is raised.
- R10: A reset write is accepted even while busy. It abandons the in-flight command, and a later done pulse from that channel has no effect.
- R11: The same opcode reaches a different target depending on the channel field. Opcode 4'b0101 with channel 4'b0100 strobes cmd_valid[4] only. With channel 4'b0001 it strobes cmd_valid[1] only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write enable, one word per cycle |
| wr_data | input | 16 | Word written to the command register |
| rd_data | output | 16 | Current register contents, reserved bits zero |
| cmd_valid | output | 16 | One-hot, single-cycle command strobe per channel |
| cmd_op | output | 4 | Opcode of the latched command |
| chan_done | input | 16 | Per-channel completion pulses |
| rst_active | output | 1 | High for the duration of the soft-reset sequence |

## Verification
The assertions take for granted that wr_en, wr_data and chan_done are known and settled at each rising edge once rst_n is high. They also assume chan_done may arrive on any channel at any time, including while a reset is pending. The stimulus drives every input on the falling edge and lets done pulses hit the latched channel, a random channel or none at all. Reset requests are kept rare so that most cycles exercise the command path, and the sequence is still entered many times, including while a command is in flight.

// File: rtl/cpcmd_pkg.sv
`timescale 1ns/1ps
package cpcmd_pkg;
    localparam int REG_W    = 16;
    localparam int OP_W     = 4;
    localparam int CH_W     = 4;
    localparam int NCH      = 1 << CH_W;
    // bit positions the host software decodes
    localparam int SRST_BIT = 15;
    localparam int OP_LSB   = 8;
    localparam int CH_LSB   = 4;
    localparam int BUSY_BIT = 0;

    typedef struct packed {
        logic            srst;
        logic            busy;
        logic [OP_W-1:0] op;
        logic [CH_W-1:0] ch;
    } cmd_state_t;
endpackage

// File: rtl/cpcmd_rstseq.sv
`timescale 1ns/1ps
module cpcmd_rstseq #(
    parameter int CYCLES = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active
);
    localparam int CW = $clog2(CYCLES + 1);

    typedef struct packed {
        logic          act;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (start) begin
            s_d.act = 1'b1;
            s_d.cnt = CW'(CYCLES - 1);
        end else if (s_q.act) begin
            if (s_q.cnt == '0) s_d.act = 1'b0;
            else               s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign active = s_q.act;
endmodule

// File: rtl/cpcmd_decode.sv
`timescale 1ns/1ps
module cpcmd_decode #(
    parameter int CH_W = 4,
    parameter int NCH  = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fire,
    input  logic [CH_W-1:0] sel,
    output logic [NCH-1:0]  strobe
);
    logic [NCH-1:0] st_d, st_q;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign st_d[i] = fire && (sel == CH_W'(i));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign strobe = st_q;
endmodule

// File: rtl/cpcmd_reg.sv
`timescale 1ns/1ps
module cpcmd_reg
    import cpcmd_pkg::*;
#(
    parameter int RST_CYCLES = 60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic [NCH-1:0]   cmd_valid,
    output logic [OP_W-1:0]  cmd_op,
    input  logic [NCH-1:0]   chan_done,
    output logic             rst_active
);
    cmd_state_t st_d, st_q;

    logic seq_active;
    logic locked;
    logic take_wr;
    logic take_rst;
    logic fire;
    logic unused_rsvd;

    assign unused_rsvd = ^{wr_data[14:12], wr_data[3:1]};

    // the command path is frozen while a reset is requested or running
    assign locked   = st_q.srst | seq_active;
    assign take_rst = wr_en & wr_data[SRST_BIT] & ~locked;
    assign take_wr  = wr_en & ~st_q.busy & ~locked;
    assign fire     = take_wr & ~wr_data[SRST_BIT] & wr_data[BUSY_BIT];

    always_comb begin
        st_d = st_q;
        if (st_q.srst) begin
            st_d.srst = 1'b0;
            st_d.busy = 1'b0;
        end else begin
            if (st_q.busy && chan_done[st_q.ch]) st_d.busy = 1'b0;
            if (take_wr) begin
                st_d.op = wr_data[OP_LSB +: OP_W];
                st_d.ch = wr_data[CH_LSB +: CH_W];
            end
            if (take_rst)  st_d.srst = 1'b1;
            else if (fire) st_d.busy = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    cpcmd_rstseq #(.CYCLES(RST_CYCLES)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (st_q.srst),
        .active (seq_active)
    );

    cpcmd_decode #(.CH_W(CH_W), .NCH(NCH)) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire   (fire),
        .sel    (wr_data[CH_LSB +: CH_W]),
        .strobe (cmd_valid)
    );

    always_comb begin
        rd_data                     = '0;
        rd_data[SRST_BIT]           = st_q.srst;
        rd_data[OP_LSB +: OP_W]     = st_q.op;
        rd_data[CH_LSB +: CH_W]     = st_q.ch;
        rd_data[BUSY_BIT]           = st_q.busy;
    end

    assign cmd_op     = st_q.op;
    assign rst_active = seq_active;
endmodule

// File: rtl/cpcmd_reg_chk.sv
`timescale 1ns/1ps
module cpcmd_reg_chk #(
    parameter int RST_CYCLES = 60
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        wr_srst,
    input logic [15:0] rd_data,
    input logic [15:0] cmd_valid,
    input logic [3:0]  cmd_op,
    input logic        rst_active
);
    logic [31:0] run_len;

    always_ff @(posedge clk) begin
        if (!rst_n)          run_len <= '0;
        else if (rst_active) run_len <= run_len + 1;
        else                 run_len <= '0;
    end

    assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[14:12] == 3'b0 && rd_data[3:1] == 3'b0);

    assert_strobe_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_valid));

    assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid != '0 |=> cmd_valid == '0);

    assert_strobe_busy_op_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid != '0 |-> rd_data[0] && cmd_op == rd_data[11:8]);

    assert_busy_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[0] && wr_en && !wr_srst |=> $stable(rd_data[11:4]) && cmd_valid == '0);

    assert_srst_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[15] |=> !rd_data[15] && !rd_data[0] && rst_active);

    assert_seq_length_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_active) |-> run_len == RST_CYCLES);

    assert_no_strobe_in_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_active |=> cmd_valid == '0);

    assert_reset_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_active && wr_en |=> $stable(rd_data[11:4]) && !rd_data[15]);
endmodule

bind cpcmd_reg cpcmd_reg_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_srst    (wr_data[15]),
    .rd_data    (rd_data),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .rst_active (rst_active)
);

// File: tb/cpcmd_reg_test.sv
`timescale 1ns/1ps
module cpcmd_reg_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [15:0] cmd_valid;
    logic [3:0]  cmd_op;
    logic [15:0] chan_done = '0;
    logic        rst_active;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference state, built from the requirements
    bit       m_srst, m_busy, m_ract;
    bit [3:0] m_op, m_ch;
    int       m_rcnt;
    int       m_strobe;

    always #10 clk = ~clk;

    cpcmd_reg uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .chan_done(chan_done), .rst_active(rst_active)
    );

    function automatic logic [15:0] exp_rd();
        return {m_srst, 3'b000, m_op, m_ch, 3'b000, m_busy};
    endfunction

    function automatic logic [15:0] exp_valid();
        return (m_strobe >= 0) ? (16'h1 << m_strobe) : 16'h0;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_edge(input bit w, input logic [15:0] d, input logic [15:0] dn);
        bit busy_old = m_busy;
        bit locked;
        m_strobe = -1;
        if (m_srst) begin
            m_srst = 0; m_busy = 0; m_ract = 1; m_rcnt = 60;
        end else begin
            locked = m_ract;
            if (m_ract) begin
                m_rcnt--;
                if (m_rcnt == 0) m_ract = 0;
            end
            if (busy_old && dn[m_ch]) m_busy = 0;
            if (w && !locked) begin
                if (!busy_old) begin
                    m_op = d[11:8];
                    m_ch = d[7:4];
                end
                if (d[15]) m_srst = 1;
                else if (d[0] && !busy_old) begin
                    m_busy = 1;
                    m_strobe = int'(d[7:4]);
                end
            end
        end
    endtask

    task automatic compare(input string tag);
        chk(tag, "rd_data", int'(rd_data), int'(exp_rd()));
        chk(tag, "cmd_valid", int'(cmd_valid), int'(exp_valid()));
        chk(tag, "rst_active", int'(rst_active), int'(m_ract));
        if (m_strobe >= 0) chk(tag, "cmd_op", int'(cmd_op), int'(m_op));
    endtask

    task automatic step(input bit w, input logic [15:0] d, input logic [15:0] dn, input string tag);
        wr_en = w; wr_data = d; chan_done = dn;
        @(posedge clk);
        model_edge(w, d, dn);
        @(negedge clk);
        wr_en = 1'b0; chan_done = '0;
        compare(tag);
    endtask

    initial begin
        void'($urandom(32'h5EED_2024));
        m_srst = 0; m_busy = 0; m_ract = 0; m_op = 0; m_ch = 0; m_rcnt = 0; m_strobe = -1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2: state out of reset
        chk("R2", "rd_data", int'(rd_data), 0);
        chk("R2", "cmd_valid", int'(cmd_valid), 0);
        chk("R2", "rst_active", int'(rst_active), 0);

        // R1 R3: idle field write with reserved bits set, no go
        step(1, 16'h7FFE, 16'h0, "R3");
        chk("R1", "masked readback", int'(rd_data), 16'h0FF0);
        chk("R3", "no strobe", int'(cmd_valid), 0);

        // R11 R4: opcode 0101 on channel 0100
        step(1, 16'h0541, 16'h0, "R11");
        chk("R11", "strobe ch4", int'(cmd_valid), 16'h0010);
        chk("R4", "cmd_op", int'(cmd_op), 5);
        chk("R4", "busy set", int'(rd_data[0]), 1);
        step(0, 16'h0, 16'h0, "R4");
        chk("R4", "strobe single cycle", int'(cmd_valid), 0);

        // R6: write while busy
        step(1, 16'h0321, 16'h0, "R6");
        chk("R6", "fields kept", int'(rd_data[11:4]), 8'h54);
        chk("R6", "no strobe", int'(cmd_valid), 0);
        // R3: zero go bit while busy leaves busy set
        step(1, 16'h0540, 16'h0, "R3");
        chk("R3", "busy not host-cleared", int'(rd_data[0]), 1);

        // R5: foreign done ignored, own done clears
        step(0, 16'h0, 16'h0004, "R5");
        chk("R5", "other channel done", int'(rd_data[0]), 1);
        step(0, 16'h0, 16'h0010, "R5");
        chk("R5", "own done", int'(rd_data[0]), 0);

        // R11: same opcode, channel 0001
        step(1, 16'h0511, 16'h0, "R11");
        chk("R11", "strobe ch1", int'(cmd_valid), 16'h0002);
        step(0, 16'h0, 16'h0002, "R5");

        // R10 R7 R8 R9: reset while busy on channel 3
        step(1, 16'h0731, 16'h0, "R10");
        step(1, 16'h8000, 16'h0, "R7");
        chk("R7", "request visible", int'(rd_data[15]), 1);
        step(0, 16'h0, 16'h0, "R7");
        chk("R7", "request cleared", int'(rd_data[15]), 0);
        chk("R10", "busy dropped", int'(rd_data[0]), 0);
        chk("R8", "sequence started", int'(rst_active), 1);
        begin
            int n = 0;
            while (rst_active && n < 100) begin
                n++;
                step(n == 5 || n == 60, 16'h0991, (n == 7) ? 16'h0008 : 16'h0, "R9");
                if (n == 5) begin
                    chk("R9", "no strobe in reset", int'(cmd_valid), 0);
                    chk("R9", "fields kept", int'(rd_data[11:4]), 8'h73);
                end
            end
            chk("R8", "active length", n, 60);
        end
        step(0, 16'h0, 16'h0008, "R10");
        chk("R10", "late done no effect", int'(rd_data), 16'h0730);

        // random traffic mixed with engine completions
        for (int i = 0; i < 4000; i++) begin
            bit          w = ($urandom % 3) == 0;
            logic [15:0] d = 16'($urandom);
            logic [15:0] dn = '0;
            d[15] = ($urandom % 25) == 0;
            d[0]  = ($urandom % 10) < 7;
            if (m_busy && ($urandom % 3) == 0)  dn = 16'h1 << m_ch;
            else if (($urandom % 8) == 0)      dn = 16'h1 << ($urandom % 16);
            step(w, d, dn, "R1 R4 R5 R6 R8 R9");
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(64'd20 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule